// File: doc/BRIEF.md
# Multi-Agent Resource Semaphore Bank

This block arbitrates exclusive ownership of a set of shared hardware resources among several software agents. Each agent has one ownership word with one bit per resource. The agent reaches that word through two bus addresses. A write to the acquire address asks for every resource whose data bit is 1. A write to the release address gives those resources back. A request is granted bit by bit, and only for resources that no other agent holds. An agent therefore learns whether it won a resource by reading its word back after the acquire write.

Each misuse sets a sticky error flag, and that flag drives an active-high interrupt. There are two kinds of misuse: asking again for a resource the agent already owns, and releasing a resource the agent does not own. Software clears the flag through a status address.

The bus accepts one access per cycle, so concurrent requests are ordered by arrival. Agents with a low index occupy 8-byte slots from one base address, and the remaining agents occupy 8-byte slots from a second base address.

Top module: `res_lock_bank`

## Requirements
- R1: After reset every ownership word reads 0 and `err_irq` is low.
- R2: An acquire write (slot offset 4) makes each requested bit 1 in the writer's word if no other agent holds that bit. A read returns its data on `bus_rdata` one cycle after the read is presented, and it shows the result of a write made in an earlier cycle.
- R3: A requested bit that another agent holds stays 0 in the writer's word. Within the same write, the free bits are still granted.
- R4: An acquire write that requests a bit the writer already owns sets the error flag and leaves the writer's word unchanged.
- R5: A release write (slot offset 0) clears every requested bit the writer owns. Requesting a bit the writer does not own sets the error flag, and no other agent's word changes.
- R6: A read at either offset of an agent's slot returns that agent's ownership word.
- R7: Agent a (a < LOW_COUNT) has its slot at LOW_BASE + 8*a. Any other agent has its slot at HIGH_BASE + 8*(a - LOW_COUNT). Addresses with bits [1:0] nonzero, or outside these slots and the status address, read as 0, and writes to them change nothing.
- R8: The error flag is sticky. A write to STATUS_ADDR with data bit 0 set clears it, and a write with bit 0 clear leaves it set. A read of STATUS_ADDR returns the flag in bit 0. A misuse in the same cycle as the clear write wins.
- R9: No resource bit is ever 1 in two agents' words at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data (resource request mask) |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| err_irq | output | 1 | Sticky misuse interrupt, active high |

## Verification
Some properties are checked on every cycle:
- no resource bit is ever held by two agents (R9);
- a redundant acquire always raises the flag on the next cycle (R4);
- a release always leaves the released bits clear (R5);
- the flag persists unless software clears it (R8);
- reads of unmapped addresses return zero (R7).

Other behaviours depend on a whole sequence and are shown only by the bench's scenarios:
- partial grants while bits are contended (R3);
- readback at both offsets (R6);
- the split address map across its two bases (R7);
- a misuse write that leaves the owner's word untouched (R4, R5).

// File: rtl/res_lock_pkg.sv
// Shared types for the resource semaphore bank.
// Assumes: one bus access per cycle, so decode yields a single access kind.
package res_lock_pkg;
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_CLEAR  = 2'd1,
        ACC_SET    = 2'd2,
        ACC_STATUS = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/res_lock_decode.sv
// Address decoder: maps a byte address to an agent slot and port, or to the status word.
// Assumes: slots are 8 bytes wide and word aligned; the two slot ranges and the
// status address do not overlap.
module res_lock_decode
    import res_lock_pkg::*;
#(
    parameter int              NUM_AGENTS  = 16,
    parameter int              LOW_COUNT   = 6,
    parameter int              ADDR_W      = 16,
    parameter logic [15:0]     LOW_BASE    = 16'h0100,
    parameter logic [15:0]     HIGH_BASE   = 16'h0200,
    parameter logic [15:0]     STATUS_ADDR = 16'h0300,
    localparam int             IDX_W       = $clog2(NUM_AGENTS)
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  agent
);
    logic [ADDR_W-1:0] slot;

    // Purpose: find which agent slot (if any) the address falls into.
    always_comb begin
        kind  = ACC_NONE;
        agent = '0;
        slot  = '0;
        if (addr == ADDR_W'(STATUS_ADDR)) kind = ACC_STATUS;
        for (int a = 0; a < NUM_AGENTS; a++) begin
            if (a < LOW_COUNT) slot = ADDR_W'(int'(LOW_BASE) + a * 8);
            else               slot = ADDR_W'(int'(HIGH_BASE) + (a - LOW_COUNT) * 8);
            if ((addr[ADDR_W-1:3] == slot[ADDR_W-1:3]) && (addr[1:0] == 2'b00)) begin
                kind  = addr[2] ? ACC_SET : ACC_CLEAR;
                agent = IDX_W'(a);
            end
        end
    end
endmodule

// File: rtl/res_lock_owners.sv
// Ownership words: one register per agent, with grant and release per bit.
// Assumes: at most one of wr_set / wr_clr is high, and both refer to 'agent'.
// Reports misuse (a redundant acquire or a release of an unowned bit) as a
// combinational pulse.
module res_lock_owners #(
    parameter int  NUM_AGENTS = 16,
    parameter int  NUM_RES    = 32,
    localparam int IDX_W      = $clog2(NUM_AGENTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_set,
    input  logic                          wr_clr,
    input  logic [IDX_W-1:0]              agent,
    input  logic [NUM_RES-1:0]            req,
    output logic [NUM_AGENTS*NUM_RES-1:0] own_flat,
    output logic                          misuse
);
    logic [NUM_RES-1:0] sel_own;

    // Purpose: the addressed agent's current word.
    assign sel_own = own_flat[int'(agent)*NUM_RES +: NUM_RES];

    // Purpose: flag requests that are redundant or invalid.
    assign misuse = (wr_set && |(req & sel_own)) || (wr_clr && |(req & ~sel_own));

    for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_agent
        logic [NUM_RES-1:0] own_q;
        logic [NUM_RES-1:0] others;

        // Purpose: union of the bits held by every other agent.
        always_comb begin
            others = '0;
            for (int k = 0; k < NUM_AGENTS; k++) begin
                if (k != g) others = others | own_flat[k*NUM_RES +: NUM_RES];
            end
        end

        // Purpose: grant free requested bits or release requested bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                own_q <= '0;
            end else if (agent == IDX_W'(g)) begin
                if (wr_set)      own_q <= own_q | (req & ~others);
                else if (wr_clr) own_q <= own_q & ~req;
            end
        end

        assign own_flat[g*NUM_RES +: NUM_RES] = own_q;
    end
endmodule

// File: rtl/res_lock_irq.sv
// Sticky misuse flag that drives the interrupt output.
// Assumes: a misuse in the same cycle as a clear request wins.
module res_lock_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic misuse,
    input  logic clr_req,
    output logic irq
);
    // Purpose: set on misuse, clear on software request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (misuse)  irq <= 1'b1;
        else if (clr_req) irq <= 1'b0;
    end
endmodule

// File: rtl/res_lock_bank.sv
// Top of the resource semaphore bank: bus decode, ownership words, sticky
// interrupt and a registered read port.
// Assumes: one access per cycle on a simple synchronous bus; read data is
// returned the cycle after the read.
module res_lock_bank
    import res_lock_pkg::*;
#(
    parameter int          NUM_AGENTS  = 16,
    parameter int          NUM_RES     = 32,
    parameter int          LOW_COUNT   = 6,
    parameter int          ADDR_W      = 16,
    parameter logic [15:0] LOW_BASE    = 16'h0100,
    parameter logic [15:0] HIGH_BASE   = 16'h0200,
    parameter logic [15:0] STATUS_ADDR = 16'h0300,
    localparam int         IDX_W       = $clog2(NUM_AGENTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NUM_RES-1:0] bus_wdata,
    output logic [NUM_RES-1:0] bus_rdata,
    output logic               err_irq
);
    acc_kind_e                     acc_kind;
    logic [IDX_W-1:0]              acc_agent;
    logic [NUM_AGENTS*NUM_RES-1:0] own_flat;
    logic                          misuse;
    logic                          wr_set, wr_clr, stat_clr;
    logic [NUM_RES-1:0]            rd_next;

    res_lock_decode #(
        .NUM_AGENTS(NUM_AGENTS), .LOW_COUNT(LOW_COUNT), .ADDR_W(ADDR_W),
        .LOW_BASE(LOW_BASE), .HIGH_BASE(HIGH_BASE), .STATUS_ADDR(STATUS_ADDR)
    ) u_decode (
        .addr(bus_addr), .kind(acc_kind), .agent(acc_agent)
    );

    // Purpose: qualify decoded writes with the bus strobes.
    assign wr_set   = bus_en && bus_we && (acc_kind == ACC_SET);
    assign wr_clr   = bus_en && bus_we && (acc_kind == ACC_CLEAR);
    assign stat_clr = bus_en && bus_we && (acc_kind == ACC_STATUS) && bus_wdata[0];

    res_lock_owners #(.NUM_AGENTS(NUM_AGENTS), .NUM_RES(NUM_RES)) u_owners (
        .clk(clk), .rst_n(rst_n), .wr_set(wr_set), .wr_clr(wr_clr),
        .agent(acc_agent), .req(bus_wdata), .own_flat(own_flat), .misuse(misuse)
    );

    res_lock_irq u_irq (
        .clk(clk), .rst_n(rst_n), .misuse(misuse), .clr_req(stat_clr), .irq(err_irq)
    );

    // Purpose: select read data for the decoded address.
    always_comb begin
        unique case (acc_kind)
            ACC_CLEAR, ACC_SET: rd_next = own_flat[int'(acc_agent)*NUM_RES +: NUM_RES];
            ACC_STATUS:         rd_next = NUM_RES'(err_irq);
            default:            rd_next = '0;
        endcase
    end

    // Purpose: register read data so it is valid the cycle after the read.
    always_ff @(posedge clk) begin
        if (!rst_n)                bus_rdata <= '0;
        else if (bus_en && !bus_we) bus_rdata <= rd_next;
    end
endmodule

// File: rtl/res_lock_chk.sv
// Checker for the semaphore bank: exclusivity, misuse reporting, release,
// sticky flag and unmapped reads. It is bound into res_lock_bank.
module res_lock_chk
    import res_lock_pkg::*;
#(
    parameter int  NUM_AGENTS = 16,
    parameter int  NUM_RES    = 32,
    localparam int IDX_W      = $clog2(NUM_AGENTS)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_en,
    input logic                          bus_we,
    input acc_kind_e                     kind,
    input logic [IDX_W-1:0]              agent,
    input logic [NUM_RES-1:0]            wdata,
    input logic [NUM_AGENTS*NUM_RES-1:0] own_flat,
    input logic [NUM_RES-1:0]            rdata,
    input logic                          irq
);
    logic [NUM_RES-1:0] sel_own;
    logic               prev_clr;
    logic [IDX_W-1:0]   prev_agent;
    logic [NUM_RES-1:0] prev_req;
    logic [NUM_RES-1:0] now_prev_own;

    assign sel_own      = own_flat[int'(agent)*NUM_RES +: NUM_RES];
    assign now_prev_own = own_flat[int'(prev_agent)*NUM_RES +: NUM_RES];

    // Purpose: remember the last release write for the check one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_clr   <= 1'b0;
            prev_agent <= '0;
            prev_req   <= '0;
        end else begin
            prev_clr   <= bus_en && bus_we && (kind == ACC_CLEAR);
            prev_agent <= agent;
            prev_req   <= wdata;
        end
    end

    for (genvar b = 0; b < NUM_RES; b++) begin : g_bit
        logic [NUM_AGENTS-1:0] column;
        always_comb begin
            for (int a = 0; a < NUM_AGENTS; a++) column[a] = own_flat[a*NUM_RES + b];
        end
        p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(column));
    end

    p_redundant_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && kind == ACC_SET && |(wdata & sel_own)) |=> irq);

    p_release_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prev_clr |-> ((now_prev_own & prev_req) == '0));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_en && bus_we && kind == ACC_STATUS && wdata[0])) |=> irq);

    p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && kind == ACC_NONE) |=> (rdata == '0));
endmodule

bind res_lock_bank res_lock_chk #(.NUM_AGENTS(NUM_AGENTS), .NUM_RES(NUM_RES)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .kind(acc_kind),
    .agent(acc_agent), .wdata(bus_wdata), .own_flat(own_flat), .rdata(bus_rdata),
    .irq(err_irq)
);

// File: tb/res_lock_bank_tb.sv
module res_lock_bank_tb;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_en, bus_we;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        err_irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    res_lock_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .err_irq(err_irq)
    );

    // Map: agents 0..5 at 0x100 + 8a, agents 6..15 at 0x200 + 8(a-6);
    // +0 release, +4 acquire; status word at 0x300.
    typedef struct packed {
        logic        rd;      // 1 = read and compare, 0 = write
        logic [15:0] addr;
        logic [31:0] data;    // write data, or expected read data
        logic        irq;     // expected err_irq afterwards
        logic [3:0]  req;     // requirement number, for the message
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 16'h0104, 32'h0000_000F, 1'b0, 4'd2},  // R2 agent0 acquires 0..3
        '{1'b1, 16'h0100, 32'h0000_000F, 1'b0, 4'd6},  // R6 read via release offset
        '{1'b0, 16'h0204, 32'h0000_00FC, 1'b0, 4'd3},  // R3 agent6 partial grant
        '{1'b1, 16'h0204, 32'h0000_00F0, 1'b0, 4'd3},
        '{1'b0, 16'h0100, 32'h0000_0003, 1'b0, 4'd5},  // R5 agent0 releases 0,1
        '{1'b1, 16'h0104, 32'h0000_000C, 1'b0, 4'd5},
        '{1'b0, 16'h024C, 32'h8000_0003, 1'b0, 4'd7},  // R7 agent15, high base
        '{1'b1, 16'h024C, 32'h8000_0003, 1'b0, 4'd7},
        '{1'b1, 16'h012C, 32'h0000_0000, 1'b0, 4'd7},  // R7 agent5 empty
        '{1'b0, 16'h012C, 32'h0000_0100, 1'b0, 4'd7},
        '{1'b1, 16'h0128, 32'h0000_0100, 1'b0, 4'd6},
        '{1'b1, 16'h0300, 32'h0000_0000, 1'b0, 4'd8},  // R8 status clean
        '{1'b1, 16'h0306, 32'h0000_0000, 1'b0, 4'd7},  // R7 unmapped read
        '{1'b0, 16'h0106, 32'hFFFF_FFFF, 1'b0, 4'd7},  // R7 misaligned write ignored
        '{1'b1, 16'h0104, 32'h0000_000C, 1'b0, 4'd7}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        do_reset();

        // R1 reset state
        bus_read(16'h0104, rd); check("R1 agent0 after reset", rd, 32'h0);
        bus_read(16'h0248, rd); check("R1 agent15 after reset", rd, 32'h0);
        check("R1 irq after reset", {31'b0, err_irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].rd) begin
                bus_read(VEC[i].addr, rd);
                check($sformatf("R%0d vec %0d rdata", VEC[i].req, i), rd, VEC[i].data);
            end else begin
                bus_write(VEC[i].addr, VEC[i].data);
            end
            check($sformatf("R%0d vec %0d irq", VEC[i].req, i), {31'b0, err_irq}, {31'b0, VEC[i].irq});
        end

        // R4 redundant acquire: agent0 owns bit 2
        bus_write(16'h0104, 32'h0000_0004);
        check("R4 irq on redundant acquire", {31'b0, err_irq}, 32'h1);
        bus_read(16'h0104, rd); check("R4 owner word unchanged", rd, 32'h0000_000C);
        bus_read(16'h0300, rd); check("R8 status reads flag", rd, 32'h1);
        bus_write(16'h0300, 32'h0000_0000);
        check("R8 write of 0 keeps flag", {31'b0, err_irq}, 32'h1);
        bus_write(16'h0300, 32'h0000_0001);
        check("R8 write of 1 clears flag", {31'b0, err_irq}, 32'h0);

        // R5 release of unowned bit: agent6 holds 0xF0, not bit 0
        bus_write(16'h0200, 32'h0000_0001);
        check("R5 irq on bad release", {31'b0, err_irq}, 32'h1);
        bus_read(16'h0204, rd); check("R5 agent6 unchanged", rd, 32'h0000_00F0);
        bus_read(16'h024C, rd); check("R5 agent15 unaffected", rd, 32'h8000_0003);
        bus_write(16'h0300, 32'h0000_0001);

        // R3 fully held request: agent1 asks for agent6's bits
        bus_write(16'h010C, 32'h0000_00F0);
        bus_read(16'h010C, rd); check("R3 held bits not granted", rd, 32'h0);
        check("R3 no irq for contention", {31'b0, err_irq}, 32'h0);

        // R2 release then re-acquire by another agent
        bus_write(16'h0200, 32'h0000_00F0);
        bus_write(16'h010C, 32'h0000_00F0);
        bus_read(16'h0108, rd); check("R2 freed bits granted", rd, 32'h0000_00F0);

        // R1 reset mid-run
        do_reset();
        bus_read(16'h010C, rd); check("R1 agent1 cleared by reset", rd, 32'h0);
        bus_read(16'h0104, rd); check("R1 agent0 cleared by reset", rd, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule